// File: doc/BRIEF.md
# Idle-State Residency Counter Register

This block is a 32-bit register that records how long the processor stays in a deep idle state. A count tick arrives at the rate of the power-management timer. The counter moves forward on a tick only while the active-low stop-clock input is low. Low stop-clock means the processor is in one of the C3 to C6 states. The count occupies the low field of the word. The upper byte is reserved, except for one writable mode bit.

Two strobes mark bus reads of the two deep-idle entry ports. These are the level 5 port and the level 6 port. If the mode bit is clear, either strobe sets the counter back to zero. If the mode bit is set, the strobes have no effect and the counter keeps counting.

Software reaches the register through a simple read/write port. The register decodes at offset 58h above a programmable I/O base. A read returns the word as it stood before any change made in that same cycle. The read data is registered and appears one clock after the read strobe.

Top module: `idle_res_reg`

## Requirements
- R1: After synchronous reset, the mode bit is 0 and a read of the register returns 00000000h.
- R2: The counter adds one in each cycle where `pm_tick` is 1 and `stop_clk_n` is 0.
- R3: The counter keeps its value in any cycle where `pm_tick` is 0, or where `stop_clk_n` is 1, provided no clearing entry strobe is present.
- R4: With the mode bit at 0, a 1 on `lvl5_rd` or on `lvl6_rd` makes the counter 0 on the next clock. This clear wins over a tick in the same cycle.
- R5: With the mode bit at 1, `lvl5_rd` and `lvl6_rd` do not change the count. The counter still advances as R2 describes.
- R6: The counter wraps from all ones to zero on an advance, and its top bit is not held after it has been set.
- R7: A read is a `bus_rd` pulse with `bus_addr` equal to `io_base` + 58h. On the clock after such a read, `bus_rdata` holds the following word: bits [CNT_W-1:0] are the count before any update in the read cycle, bit 24 is the mode bit, and all other bits are 0.
- R8: A write at `io_base` + 58h loads the mode bit from `bus_wdata[24]`. The counter ignores the other bits of the write data.
- R9: A write at any other address leaves the mode bit unchanged. On the clock after a read at any other address, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_base | input | ADDR_W | Programmable power-management I/O base |
| bus_addr | input | ADDR_W | Access address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pm_tick | input | 1 | Count tick at the power-management timer rate |
| stop_clk_n | input | 1 | Active-low stop-clock indication |
| lvl5_rd | input | 1 | Level 5 entry-port read strobe |
| lvl6_rd | input | 1 | Level 6 entry-port read strobe |

## Verification
The assertions assume the following about the inputs:
- All inputs change only between clock edges.
- `bus_rd` and `bus_wr` are never high in the same cycle.
- Each entry strobe lasts one cycle.

The bench drives every input on the falling edge, so it meets these conditions. It never overlaps a read with a write.

The bench sweeps all 16 combinations of tick, stop-clock and the two entry strobes under both mode values, with a register read in the same cycle. It compares each result with a count model kept modulo 2^CNT_W. Wrap is covered by a small counter width.

// File: rtl/idle_res_pkg.sv
package idle_res_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned MODE_POS = 24;
  localparam int unsigned REG_OFFSET = 32'h58;

  typedef struct packed {
    logic rd;
    logic wr;
  } bus_hit_t;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_STEP  = 2'd1,
    CNT_CLEAR = 2'd2
  } cnt_op_t;
endpackage

// File: rtl/idle_res_decode.sv
module idle_res_decode
  import idle_res_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] io_base,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output bus_hit_t          hit
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);

  logic [ADDR_W-1:0] reg_addr;
  logic              match;

  always_comb begin
    reg_addr = io_base + OFF;
    match    = (bus_addr == reg_addr);
    hit.rd   = bus_rd & match;
    hit.wr   = bus_wr & match;
  end
endmodule

// File: rtl/idle_res_mode_reg.sv
module idle_res_mode_reg
  import idle_res_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic mode
);
  always_ff @(posedge clk) begin
    if (rst) mode <= 1'b0;
    else if (wr_hit) mode <= wr_bit;
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> mode == $past(wr_bit)); // R8
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(mode)); // R9
endmodule

// File: rtl/idle_res_counter.sv
module idle_res_counter
  import idle_res_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_t          op,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else begin
      case (op)
        CNT_CLEAR: cnt <= '0;
        CNT_STEP:  cnt <= cnt + 1'b1;
        default:   cnt <= cnt;
      endcase
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (op == CNT_STEP) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (op == CNT_STEP && &cnt) |=> cnt == '0); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op == CNT_HOLD) |=> $stable(cnt)); // R3
endmodule

// File: rtl/idle_res_reg.sv
module idle_res_reg
  import idle_res_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_base,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              pm_tick,
  input  logic              stop_clk_n,
  input  logic              lvl5_rd,
  input  logic              lvl6_rd
);
  localparam int unsigned PAD_W = WORD_W - CNT_W;

  bus_hit_t          hit;
  logic              mode;
  logic [CNT_W-1:0]  cnt;
  cnt_op_t           op;
  logic              entry;
  logic              advance;
  logic [WORD_W-1:0] word;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  idle_res_decode #(.ADDR_W(ADDR_W)) u_dec (
    .io_base(io_base), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .hit(hit)
  );

  idle_res_mode_reg u_mode (
    .clk(clk), .rst(rst), .wr_hit(hit.wr),
    .wr_bit(bus_wdata[MODE_POS]), .mode(mode)
  );

  always_comb begin
    entry   = lvl5_rd | lvl6_rd;
    advance = pm_tick & ~stop_clk_n;
    if (entry && !mode) op = CNT_CLEAR;
    else if (advance)   op = CNT_STEP;
    else                op = CNT_HOLD;
  end

  idle_res_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .op(op), .cnt(cnt)
  );

  always_comb begin
    word = {{PAD_W{1'b0}}, cnt};
    word[MODE_POS] = mode;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= hit.rd ? word : '0;
  end

  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (entry && !mode) |=> cnt == '0); // R4
  AST_ENTRY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (entry && mode && !advance) |=> $stable(cnt)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[WORD_W-1:MODE_POS+1] == '0)); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit.rd) |=> bus_rdata == '0); // R9
endmodule

// File: tb/idle_res_reg_tb.sv
module idle_res_reg_tb;
  localparam int CW = 6;
  localparam int AW = 16;

  logic clk = 0, rst = 1;
  logic [AW-1:0] io_base = 16'h0400, bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic pm_tick = 0, stop_clk_n = 1, lvl5_rd = 0, lvl6_rd = 0;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  bit exp_mode = 0;

  always #10 clk = ~clk;

  idle_res_reg #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .io_base(io_base), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pm_tick(pm_tick), .stop_clk_n(stop_clk_n),
    .lvl5_rd(lvl5_rd), .lvl6_rd(lvl6_rd)
  );

  function automatic logic [31:0] word_of(int c, bit m);
    logic [31:0] w;
    w = 32'(c % (1 << CW));
    w[24] = m;
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit t, bit s, bit l5, bit l6, bit rd, logic [AW-1:0] a);
    pm_tick = t; stop_clk_n = s; lvl5_rd = l5; lvl6_rd = l6;
    bus_rd = rd; bus_addr = a;
    @(negedge clk);
    pm_tick = 0; stop_clk_n = 1; lvl5_rd = 0; lvl6_rd = 0; bus_rd = 0;
    if ((l5 || l6) && !exp_mode) exp_cnt = 0;
    else if (t && !s) exp_cnt = (exp_cnt + 1) % (1 << CW);
  endtask

  task automatic read_chk(string req);
    step(0, 1, 0, 0, 1, io_base + 16'h58);
    check(req, bus_rdata, word_of(exp_cnt, exp_mode));
  endtask

  task automatic write_reg(logic [AW-1:0] a, logic [31:0] d, bit hits);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (hits) exp_mode = d[24];
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    read_chk("R1");

    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, '0);
    read_chk("R2");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0, '0);
    step(0, 0, 0, 0, 0, '0);
    read_chk("R3");

    for (int i = 0; i < 64 + 3; i++) step(1, 0, 0, 0, 0, '0);
    read_chk("R6");

    step(1, 0, 1, 0, 0, '0);
    read_chk("R4");
    step(1, 0, 0, 0, 0, '0);
    step(1, 0, 0, 1, 0, '0);
    read_chk("R4");

    write_reg(io_base + 16'h58, 32'hFFFF_FFFF, 1);
    read_chk("R8");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, '0);
    step(0, 0, 1, 0, 0, '0);
    step(0, 0, 0, 1, 0, '0);
    read_chk("R5");
    step(1, 0, 1, 1, 0, '0);
    read_chk("R5");

    write_reg(io_base + 16'h5C, 32'h0, 0);
    read_chk("R9");
    step(0, 1, 0, 0, 1, io_base + 16'h54);
    check("R9", bus_rdata, 32'h0);

    for (int m = 0; m < 2; m++) begin
      write_reg(io_base + 16'h58, m ? 32'h0100_0000 : 32'h0, 1);
      for (int k = 0; k < 16; k++) begin
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, '0);
        begin
          logic [31:0] pre;
          pre = word_of(exp_cnt, exp_mode);
          step(k[0], k[1], k[2], k[3], 1, io_base + 16'h58);
          check("R7", bus_rdata, pre);
        end
        read_chk(exp_mode ? "R5" : "R4");
      end
    end

    while (exp_cnt != (1 << CW) - 1) step(1, 0, 0, 0, 0, '0);
    read_chk("R6");
    step(1, 0, 0, 0, 0, '0);
    read_chk("R6");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule